// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt requests from a parameterised set of peripheral sources and presents at most one vector to a processor core. Each request pulse sets a sticky pending flag for its source. The flag stays set until software clears it. A per-source enable decides whether a pending flag may raise the request line. A per-source priority bit places the source in the high level or the low level.

The controller keeps a two-bit in-service record, with one bit for the low level and one for the high level. The core pulses an acknowledge strobe when it takes the offered vector. It pulses a return strobe when a handler finishes.

A running handler blocks every request of its own level and of any lower level. A high-level request may interrupt a running low-level handler. Within a level, the lowest source index wins. When a handler returns and work is still waiting, the next vector appears in the cycle after the return strobe, with no idle gap.

Top module: `irq2_ctrl`

## Requirements
- R1: After reset, all pending flags are clear, `irq_o` is 0 and `insvc_o` is 2'b00. A one-cycle pulse on `req_i[i]` sets flag i. Flag i stays set, even while source i is disabled, until a cycle in which `clr_i[i]` is 1 and `req_i[i]` is 0.
- R2: When `req_i[i]` and `clr_i[i]` are both 1 in the same cycle, flag i is left set.
- R3: `irq_o` is 1 only when some source has its flag set, has `en_i` set, and belongs to a level the in-service state allows. A pending source whose `en_i` bit is 0 never raises `irq_o`.
- R4: Among takeable sources of one level, the lowest index is offered on `vec_o`.
- R5: `hi_i[i]`=1 marks source i as high level. A takeable high-level source is offered ahead of any low-level one. This holds when both arrive in the same cycle, and also when the low-level one was already being offered but not yet acknowledged. `vec_hi_o` reports the level of the offered vector.
- R6: A running handler is never preempted by a request of the same or lower level. `insvc_o` is {high active, low active}. When the high bit is 1, `irq_o` is 0. When only the low bit is 1, only high-level sources raise `irq_o`.
- R7: A high-level vector acknowledged during a low-level handler sets `insvc_o` to 2'b11. The following return strobe gives 2'b01, so the low-level handler resumes.
- R8: `ack_i` while `irq_o`=1 sets the in-service bit of the offered level. `reti_i` clears the highest active bit. `reti_i` with `insvc_o`=2'b00 leaves the state unchanged.
- R9: If any takeable source is pending when a return strobe lowers the in-service state, `irq_o` is 1 in the cycle after the strobe (tail-chaining). This includes the source whose flag was never cleared, which re-raises its own vector.
- R10: Once a vector is offered, `vec_o` keeps that value until it is acknowledged, even when a lower-index request of the same level arrives. The exceptions are the R5 high-level upgrade and the loss of the offered source's flag or enable.
- R11: A request pulse that arrives while its flag is still set is lost. A pulse that arrives after the flag was cleared, while the handler is still running, sets the flag again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NSRC | Request pulses, one per source |
| en_i | input | NSRC | Per-source enable |
| hi_i | input | NSRC | Per-source level, 1 = high |
| clr_i | input | NSRC | Software clear, one bit per pending flag |
| ack_i | input | 1 | Core takes the offered vector |
| reti_i | input | 1 | Core returns from a handler |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | IW | Offered source index |
| vec_hi_o | output | 1 | Level of the offered vector |
| insvc_o | output | 2 | In-service state {high, low} |

## Verification
The bench builds the controller with six sources. A width that is not a power of two means the index width of three bits has two codes that never name a source. Six sources are enough to place a low-index and a high-index request in both levels at once. That makes the lowest-index rule, the high-over-low upgrade of an unacknowledged vector and the hold of an offered vector all reachable in short directed sequences. Nesting, tail-chaining and lost timer events are driven through the acknowledge and return strobes exactly as a core would issue them.

// File: rtl/irq2_pkg.sv
package irq2_pkg;

    // In-service record: one bit per priority level
    typedef struct packed {
        logic hi;
        logic lo;
    } svc_t;

    // Can a request of the given level be taken under state s?
    function automatic logic level_open(svc_t s, logic lvl_hi);
        if (lvl_hi) begin
            return !s.hi;
        end
        return !s.hi && !s.lo;
    endfunction

    // Retire the highest active level
    function automatic svc_t svc_retire(svc_t s);
        svc_t r;
        r = s;
        if (s.hi) begin
            r.hi = 1'b0;
        end else begin
            r.lo = 1'b0;
        end
        return r;
    endfunction

    // Mark a level as entered
    function automatic svc_t svc_enter(svc_t s, logic lvl_hi);
        svc_t r;
        r = s;
        if (lvl_hi) begin
            r.hi = 1'b1;
        end else begin
            r.lo = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/irq2_pending.sv
module irq2_pending #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr) | req;
        end
    end

    // R2
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |=> ((pend & $past(req)) == $past(req)));

    // R1
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(pend & ~clr)) == $past(pend & ~clr)));

endmodule

// File: rtl/irq2_pick.sv
module irq2_pick
    import irq2_pkg::*;
#(
    parameter  int NSRC = 8,
    localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] elig,
    input  logic [NSRC-1:0] prio,
    input  svc_t            svc,
    output logic            cv,
    output logic            chi,
    output logic [IW-1:0]   cidx
);

    logic [NSRC-1:0] hi_m, lo_m;
    logic [IW-1:0]   hi_idx, lo_idx;
    logic            take_hi, take_lo;

    always_comb begin
        hi_m   = elig & prio;
        lo_m   = elig & ~prio;
        hi_idx = '0;
        lo_idx = '0;
        // descending scan leaves the lowest set index
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hi_m[i]) hi_idx = IW'(i);
            if (lo_m[i]) lo_idx = IW'(i);
        end
        take_hi = (|hi_m) && level_open(svc, 1'b1);
        take_lo = (|lo_m) && level_open(svc, 1'b0);
        cv      = take_hi || take_lo;
        chi     = take_hi;
        cidx    = take_hi ? hi_idx : lo_idx;
    end

endmodule

// File: rtl/irq2_svc.sv
module irq2_svc
    import irq2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic take_hi,
    input  logic reti,
    output svc_t svc
);

    svc_t nxt;

    always_comb begin
        nxt = svc;
        if (reti) nxt = svc_retire(nxt);
        if (take) nxt = svc_enter(nxt, take_hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            svc <= '0;
        end else begin
            svc <= nxt;
        end
    end

    // R8
    idle_reti_chk: assert property (@(posedge clk) disable iff (rst)
        (reti && !take && svc == 2'b00) |=> (svc == 2'b00));

    // R7
    resume_low_chk: assert property (@(posedge clk) disable iff (rst)
        (reti && !take && svc == 2'b11) |=> (svc == 2'b01));

endmodule

// File: rtl/irq2_ctrl.sv
module irq2_ctrl
    import irq2_pkg::*;
#(
    parameter  int NSRC = 8,
    localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] hi_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic            ack_i,
    input  logic            reti_i,
    output logic            irq_o,
    output logic [IW-1:0]   vec_o,
    output logic            vec_hi_o,
    output logic [1:0]      insvc_o
);

    logic [NSRC-1:0] pend, elig;
    svc_t            svc;
    logic            cv, chi;
    logic [IW-1:0]   cidx;

    // offered-vector hold
    logic            hold_v, hold_hi;
    logic [IW-1:0]   hold_idx;
    logic            hold_ok, upgrade;

    irq2_pending #(.NSRC(NSRC)) u_pend (
        .clk (clk),
        .rst (rst),
        .req (req_i),
        .clr (clr_i),
        .pend(pend)
    );

    assign elig = pend & en_i;

    irq2_pick #(.NSRC(NSRC)) u_pick (
        .elig(elig),
        .prio(hi_i),
        .svc (svc),
        .cv  (cv),
        .chi (chi),
        .cidx(cidx)
    );

    always_comb begin
        hold_ok = hold_v && elig[hold_idx] && (hi_i[hold_idx] == hold_hi)
                  && level_open(svc, hold_hi);
        upgrade = cv && chi && !hold_hi;
        if (hold_ok && !upgrade) begin
            irq_o    = 1'b1;
            vec_o    = hold_idx;
            vec_hi_o = hold_hi;
        end else begin
            irq_o    = cv;
            vec_o    = cidx;
            vec_hi_o = chi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v   <= 1'b0;
            hold_hi  <= 1'b0;
            hold_idx <= '0;
        end else if (ack_i) begin
            hold_v   <= 1'b0;
        end else begin
            hold_v   <= irq_o;
            hold_hi  <= vec_hi_o;
            hold_idx <= vec_o;
        end
    end

    irq2_svc u_svc (
        .clk    (clk),
        .rst    (rst),
        .take   (ack_i && irq_o),
        .take_hi(vec_hi_o),
        .reti   (reti_i),
        .svc    (svc)
    );

    assign insvc_o = svc;

    // R6
    no_nest_under_hi_chk: assert property (@(posedge clk) disable iff (rst)
        svc.hi |-> !irq_o);

    // R3
    offered_is_live_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend[vec_o] && en_i[vec_o]));

    // R5
    hi_first_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !vec_hi_o) |-> ((pend & en_i & hi_i) == '0));

endmodule

// File: tb/irq2_ctrl_test.sv
module irq2_ctrl_test;

    localparam int N  = 6;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  req, en, hi, clr;
    logic          ack, reti;
    logic          irq;
    logic [IW-1:0] vec;
    logic          vhi;
    logic [1:0]    svc;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq2_ctrl #(.NSRC(N)) uut (
        .clk(clk), .rst(rst), .req_i(req), .en_i(en), .hi_i(hi),
        .clr_i(clr), .ack_i(ack), .reti_i(reti),
        .irq_o(irq), .vec_o(vec), .vec_hi_o(vhi), .insvc_o(svc)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse(logic [N-1:0] m);
        req = m; step(); req = '0;
    endtask

    task automatic clear(logic [N-1:0] m);
        clr = m; step(); clr = '0;
    endtask

    task automatic take();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic ret();
        reti = 1'b1; step(); reti = 1'b0;
    endtask

    task automatic cleanup();
        clr = '1; step(); ret(); ret(); clr = '0;
        en = '1; hi = '0; step();
    endtask

    task automatic t_reset();
        chk("R1 reset irq", irq, 0);
        chk("R1 reset insvc", svc, 0);
    endtask

    task automatic t_enable();
        en = '0;
        pulse(6'b010000);
        chk("R3 disabled no irq", irq, 0);
        step();
        en = '1; step();
        chk("R1 kept while disabled irq", irq, 1);
        chk("R1 kept while disabled vec", vec, 4);
        clear(6'b010000);
        chk("R1 clear drops irq", irq, 0);
        cleanup();
    endtask

    task automatic t_order();
        pulse(6'b101010);
        chk("R4 lowest index", vec, 1);
        clear(6'b000010);
        chk("R4 next index", vec, 3);
        chk("R4 irq", irq, 1);
        cleanup();
    endtask

    task automatic t_hi_first();
        hi = 6'b100000;
        pulse(6'b100001);
        chk("R5 same cycle vec", vec, 5);
        chk("R5 same cycle level", vhi, 1);
        cleanup();
        hi = 6'b100000;
        pulse(6'b000001);
        chk("R5 low offered", vec, 0);
        pulse(6'b100000);
        chk("R5 upgrade vec", vec, 5);
        chk("R5 upgrade level", vhi, 1);
        cleanup();
    endtask

    task automatic t_hold_chain();
        pulse(6'b001000);
        chk("R10 first vec", vec, 3);
        pulse(6'b000010);
        chk("R10 held vec", vec, 3);
        take();
        chk("R8 ack low", svc, 1);
        chk("R6 low blocks low", irq, 0);
        clear(6'b001000);
        chk("R6 still blocked", irq, 0);
        ret();
        chk("R9 tail chain irq", irq, 1);
        chk("R9 tail chain vec", vec, 1);
        chk("R8 return idle", svc, 0);
        cleanup();
    endtask

    task automatic t_preempt();
        hi = 6'b010000;
        pulse(6'b000100);
        take();
        chk("R8 low entered", svc, 1);
        pulse(6'b010000);
        chk("R7 hi preempts irq", irq, 1);
        chk("R7 hi preempts vec", vec, 4);
        take();
        chk("R7 nested state", svc, 3);
        chk("R6 hi blocks all", irq, 0);
        clear(6'b010000);
        pulse(6'b000001);
        chk("R6 low under hi", irq, 0);
        ret();
        chk("R7 low resumes", svc, 1);
        chk("R6 low waits", irq, 0);
        ret();
        chk("R9 chain after nest irq", irq, 1);
        chk("R9 chain after nest vec", vec, 0);
        cleanup();
        ret();
        chk("R8 idle return ignored", svc, 0);
        chk("R8 idle return irq", irq, 0);
    endtask

    task automatic t_same_vec();
        pulse(6'b001000);
        take();
        ret();
        chk("R9 uncleared re-raise irq", irq, 1);
        chk("R9 uncleared re-raise vec", vec, 3);
        cleanup();
    endtask

    task automatic t_set_wins();
        req = 6'b000100; clr = 6'b000100; step();
        req = '0; clr = '0;
        chk("R2 set wins irq", irq, 1);
        chk("R2 set wins vec", vec, 2);
        cleanup();
    endtask

    task automatic t_lost();
        pulse(6'b000010);
        take();
        pulse(6'b000010);
        clear(6'b000010);
        ret();
        chk("R11 lost event irq", irq, 0);
        cleanup();
        pulse(6'b000010);
        take();
        clear(6'b000010);
        pulse(6'b000010);
        ret();
        chk("R11 re-set irq", irq, 1);
        chk("R11 re-set vec", vec, 1);
        cleanup();
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; req = '0; en = '1; hi = '0; clr = '0;
        ack = 1'b0; reti = 1'b0;
        step(); step();
        rst = 1'b0; step();
        t_reset();
        t_enable();
        t_order();
        t_hi_first();
        t_hold_chain();
        t_preempt();
        t_same_vec();
        t_set_wins();
        t_lost();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule